// File: doc/BRIEF.md
# Per-Priority Pause Timer Bank

This block keeps one pause-time counter for each traffic priority of a full-duplex network receiver. When the frame decoder extracts a pause quantum for a priority, it pulses that priority's load strobe and presents the value. The counter takes the new value at once, even if an earlier pause is still running. It then counts down one step for every 512 bit times. The transmitter reads an eight-bit vector that shows which priorities must hold off sending.

A test mode replaces the 512-bit-time step with one step per receive clock, but only while the transmitter reports that it has stopped. When a counter counts down to zero, the block sets a sticky interrupt if the mask allows it. Loading a zero quantum does the same. The interrupt stays set until a clear strobe arrives.

Top module: `pfc_pause_bank`

## Requirements
- R1: Eight independent 16-bit counters exist. A pulse on `load_en[i]` loads counter i with `load_val[16*i+15:16*i]` on that clock edge. Other counters are not touched by that load.
- R2: A load replaces the counter value even while that counter is still counting down.
- R3: `paused[i]` is high exactly when counter i is nonzero. A counter at zero never steps below zero and stays at zero until a load.
- R4: With `test_mode` low, a 9-bit prescaler counts clock cycles with `bit_tick` high, and a counter step happens on the 512th such tick. Any load restarts the prescaler at zero, and no step happens in the cycle of a load.
- R5: With `test_mode` high, every counter steps on each clock edge where `tx_stopped` is high. No counter steps while `tx_stopped` is low, and `bit_tick` has no effect in this mode.
- R6: A counter that steps from one to zero sets `irq`, provided `irq_mask` is high in that cycle.
- R7: Loading the value zero clears the priority's paused bit after that edge and sets `irq`, provided `irq_mask` is high.
- R8: `irq` is sticky. A high `irq_clr` clears it, but a new set event in the same cycle wins. No set event happens while `irq_mask` is low.
- R9: After reset, all counters and the prescaler are zero, and `paused` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 8 | Per-priority load strobe |
| load_val | input | 128 | Pause quanta, 16 bits per priority, priority 0 in the low bits |
| bit_tick | input | 1 | One pulse per bit time |
| test_mode | input | 1 | Step on every receive clock while the transmitter is stopped |
| tx_stopped | input | 1 | Transmitter has halted |
| irq_mask | input | 1 | Allows the interrupt to be set |
| irq_clr | input | 1 | Clears the sticky interrupt |
| paused | output | 8 | Per-priority pause active |
| irq | output | 1 | Sticky pause interrupt |

## Verification
The properties assume the following about the inputs:
- Every input is known from the first edge after reset.
- Inputs change only between clock edges.
- A quiet interval in normal mode is one with `bit_tick` low and no load. In test mode, a quiet interval is one with `tx_stopped` low.

The stimulus drives every input on the falling edge, so each rising edge sees settled values. Load values are kept small or zero so that countdowns finish within the run. Test mode and the transmit-stopped flag are toggled only from the bench's own sequences or its random phase. A reference model follows the same input stream on every clock.

// File: rtl/pfc_pause_bank.sv
module pfc_pause_bank #(
  parameter int NPRIO = 8,
  parameter int QW    = 16,
  parameter int PRE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPRIO-1:0]    load_en,
  input  logic [NPRIO*QW-1:0] load_val,
  input  logic                bit_tick,
  input  logic                test_mode,
  input  logic                tx_stopped,
  input  logic                irq_mask,
  input  logic                irq_clr,
  output logic [NPRIO-1:0]    paused,
  output logic                irq
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;
  localparam logic [QW-1:0]    ONE      = QW'(1);

  logic [PRE_W-1:0] pre_q;
  logic [NPRIO-1:0] hit;
  logic             any_load;
  logic             step;

  assign any_load = |load_en;
  assign step     = test_mode ? tx_stopped
                              : (bit_tick && pre_q == PRE_LAST && !any_load);

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_q <= '0;
    else if (any_load) pre_q <= '0;
    else if (bit_tick) pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < NPRIO; g++) begin : g_prio
    logic [QW-1:0] cnt_q;
    logic [QW-1:0] ld_v;
    assign ld_v = load_val[g*QW +: QW];

    always_ff @(posedge clk) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load_en[g])           cnt_q <= ld_v;
      else if (step && cnt_q != '0)  cnt_q <= cnt_q - ONE;
    end

    assign paused[g] = |cnt_q;
    assign hit[g]    = load_en[g] ? (ld_v == '0) : (step && cnt_q == ONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 irq <= 1'b0;
    else if (irq_mask && |hit)  irq <= 1'b1;
    else if (irq_clr)           irq <= 1'b0;
  end
endmodule

module pfc_pause_bank_chk #(
  parameter int NPRIO = 8,
  parameter int QW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPRIO-1:0]    load_en,
  input logic [NPRIO*QW-1:0] load_val,
  input logic                bit_tick,
  input logic                test_mode,
  input logic                tx_stopped,
  input logic                irq_mask,
  input logic                irq_clr,
  input logic [NPRIO-1:0]    paused,
  input logic                irq
);
  for (genvar g = 0; g < NPRIO; g++) begin : g_lane
    // R1
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en[g] |=> paused[g] == (|$past(load_val[g*QW +: QW])));
    // R3
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!paused[g] && !load_en[g]) |=> !paused[g]);
  end

  // R4
  idle_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !bit_tick && load_en == '0) |=> $stable(paused));
  // R5
  idle_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !tx_stopped && load_en == '0) |=> $stable(paused));
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_mask));
endmodule

bind pfc_pause_bank pfc_pause_bank_chk #(.NPRIO(NPRIO), .QW(QW)) u_chk (.*);

// File: tb/tb_pfc_pause_bank.sv
module tb_pfc_pause_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   load_en = '0;
  logic [127:0] load_val = '0;
  logic         bit_tick = 1'b0, test_mode = 1'b0, tx_stopped = 1'b0;
  logic         irq_mask = 1'b0, irq_clr = 1'b0;
  logic [7:0]   paused;
  logic         irq;

  int checks = 0, errors = 0;
  bit done = 0, run_cmp = 0;

  always #10 clk = ~clk;

  pfc_pause_bank dut (.*);

  int m_cnt [8];
  int m_pre;
  bit m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_pre = 0;
      m_irq = 0;
    end else begin
      bit any, stp, hit;
      any = (load_en != 0);
      stp = test_mode ? tx_stopped : (bit_tick && m_pre == 511 && !any);
      hit = 0;
      for (int i = 0; i < 8; i++) begin
        if (load_en[i]) begin
          m_cnt[i] = int'(load_val[i*16 +: 16]);
          if (m_cnt[i] == 0) hit = 1;
        end else if (stp && m_cnt[i] > 0) begin
          m_cnt[i]--;
          if (m_cnt[i] == 0) hit = 1;
        end
      end
      if (any) m_pre = 0;
      else if (bit_tick) m_pre = (m_pre + 1) % 512;
      if (hit && irq_mask) m_irq = 1;
      else if (irq_clr) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      logic [7:0] ep;
      for (int i = 0; i < 8; i++) ep[i] = (m_cnt[i] != 0);
      checks++;
      if (paused !== ep) begin
        errors++;
        $display("FAIL R3 model paused actual=%h expected=%h", paused, ep);
      end
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R8 model irq actual=%b expected=%b", irq, m_irq);
      end
    end
  end

  task automatic chk(input logic [7:0] ep, input logic ei, input string tag);
    checks++;
    if (paused !== ep || irq !== ei) begin
      errors++;
      $display("FAIL %s paused/irq actual=%h/%b expected=%h/%b", tag, paused, irq, ep, ei);
    end
  endtask

  task automatic load1(input int p, input int v);
    load_en = '0;
    load_en[p] = 1'b1;
    load_val[p*16 +: 16] = 16'(v);
    @(negedge clk);
    load_en = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(8'h00, 1'b0, "R9 reset");
    run_cmp = 1;

    // R1 R4 R6: two lanes, normal mode, tick every cycle
    irq_mask = 1'b1;
    bit_tick = 1'b1;
    load_en = 8'b0000_1001;
    load_val[0 +: 16] = 16'd2;
    load_val[48 +: 16] = 16'd1;
    @(negedge clk);
    load_en = '0;
    chk(8'h09, 1'b0, "R1 load lanes 0,3");
    repeat (511) @(negedge clk);
    chk(8'h09, 1'b0, "R4 no step before 512 ticks");
    @(negedge clk);
    chk(8'h01, 1'b1, "R6 zero reached sets irq");

    // R8: clear, then masked zero-crossing
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(8'h01, 1'b0, "R8 clear");
    irq_mask = 1'b0;
    repeat (512) @(negedge clk);
    chk(8'h00, 1'b0, "R8 masked no irq");
    irq_mask = 1'b1;

    // R2 overwrite, then R5 test mode
    load1(5, 100);
    repeat (99) @(negedge clk);
    load1(5, 3);
    bit_tick = 1'b0;
    chk(8'h20, 1'b0, "R2 overwrite running count");
    test_mode = 1'b1;
    tx_stopped = 1'b0;
    bit_tick = 1'b1;
    repeat (5) @(negedge clk);
    chk(8'h20, 1'b0, "R5 no step while tx running");
    tx_stopped = 1'b1;
    repeat (2) @(negedge clk);
    chk(8'h20, 1'b0, "R5 two test steps");
    @(negedge clk);
    chk(8'h00, 1'b1, "R5 third test step reaches zero");

    // R7 zero-quantum load, R3 zero holds
    tx_stopped = 1'b0;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(8'h00, 1'b0, "R8 clear before R7");
    load1(2, 50);
    chk(8'h04, 1'b0, "R1 load lane 2");
    load1(2, 0);
    chk(8'h00, 1'b1, "R7 zero quantum ends pause");
    tx_stopped = 1'b1;
    repeat (3) @(negedge clk);
    chk(8'h00, 1'b1, "R3 zero counter stays zero");
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    bit_tick = 1'b0;

    // random phase, compared against the model every clock
    for (int n = 0; n < 4000; n++) begin
      load_en = '0;
      if ($urandom_range(0, 19) == 0) begin
        int p;
        p = $urandom_range(0, 7);
        load_en[p] = 1'b1;
        load_val[p*16 +: 16] = 16'($urandom_range(0, 5));
      end
      bit_tick   = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 199) == 0) test_mode = ~test_mode;
      tx_stopped = ($urandom_range(0, 9) == 0);
      irq_mask   = ($urandom_range(0, 4) != 0);
      irq_clr    = ($urandom_range(0, 15) == 0);
      @(negedge clk);
    end
    load_en = '0;
    irq_clr = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule